// File: doc/BRIEF.md
# Bus Controller Instruction-List Sequencer

This block runs a command/response serial bus controller from a list of instructions kept in RAM. Each list entry is two words: an opcode word and a parameter word. The sequencer fetches entries through its own list pointer. For a message entry, the parameter points to a message descriptor. The sequencer reads the descriptor's control and command words and starts the external transmit/receive engine. When the message is finished, it writes the outcome back into the descriptor.

Other opcodes jump within the list, end a frame, pulse one of four user interrupts, post a word to a general-purpose queue, or halt. A frame can run once or repeat. Repeated frames are paced either by an internal frame counter or by an external trigger. A failed message can be retried twice, and the last retry goes out on the other bus.

The host sets the list start while the sequencer is idle and then pulses start. The live pointer can be read at all times.

Top module: `bcseq_top`

## Requirements
- R1: After reset the block is idle: busy_o, halted_o, err_o, q_valid_o, msg_start_o are 0, irq_o is 0 and ptr_o is 0.
- R2: While idle, ptr_load_i copies ptr_init_i into the pointer. An entry is read as the opcode word at the pointer, then the parameter word at pointer+1. The pointer then advances by 2. The opcode is in bits [3:0].
- R3: Opcode 0 (message) reads descriptor word 0 (control) and word 1 (command) at the parameter address. If control bit 1 (bus-to-bus transfer) is set, it also reads word 8 (second command). It then pulses msg_start_o for one cycle, with the command, second command and bus on the message outputs.
- R4: After a message, the sequencer writes three things. It writes the block status to descriptor word 5: bit 15 = 1, bit 14 = failed, bit 2 = alternate bus used, bits [1:0] = retries used. It writes the engine status to word 7. For a bus-to-bus transfer it also writes the second status to word 9.
- R5: With control bit 0 (retry enable) set, a failed attempt is repeated up to 2 times. The bus is control bit 2 for the first attempt and the first retry, and the inverted bit 2 for the second retry.
- R6: With control bit 0 clear, a failed message is attempted exactly once.
- R7: Opcode 1 loads the parameter into the pointer.
- R8: Opcode 3 pulses irq_o[param[1:0]] for one cycle. The other interrupt lines stay low.
- R9: Opcode 4 presents the parameter on q_data_o with q_valid_o high for one cycle.
- R10: Opcode 5 stops the sequencer with halted_o = 1. Any opcode from 6 to 15 also stops it with halted_o = 1 and err_o = 1.
- R11: With auto_rep_i = 0, opcode 2 ends the run: busy_o goes low and halted_o stays 0.
- R12: With auto_rep_i = 1 and ext_mode_i = 0, opcode 2 waits for a frame start and then resumes at the list start. Frame starts occur every frame_period_i cycles (period at least 1) counted from start_i.
- R13: With auto_rep_i = 1 and ext_mode_i = 1, frame starts come only from rising edges of ext_trig_i. The internal counter has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| ptr_load_i | input | 1 | Load list pointer when idle |
| ptr_init_i | input | AW | List start address |
| ptr_o | output | AW | Current list pointer |
| auto_rep_i | input | 1 | 1 = repeat frames |
| ext_mode_i | input | 1 | 1 = frames paced by external trigger |
| frame_period_i | input | TW | Frame period in cycles |
| ext_trig_i | input | 1 | External frame trigger |
| mem_req_o | output | 1 | RAM access strobe |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | AW | RAM address |
| mem_wdata_o | output | DW | RAM write data |
| mem_rdata_i | input | DW | RAM read data, one cycle after request |
| msg_start_o | output | 1 | Start one message attempt |
| msg_ctrl_o | output | DW | Descriptor control word |
| msg_cmd_o | output | DW | Command word |
| msg_cmd2_o | output | DW | Second command word |
| msg_bus_o | output | 1 | Bus selected for this attempt |
| msg_done_i | input | 1 | Attempt finished |
| msg_ok_i | input | 1 | Attempt succeeded, valid with done |
| msg_stat_i | input | DW | Status from the responder |
| msg_stat2_i | input | DW | Second status for bus-to-bus transfers |
| irq_o | output | NIRQ | User interrupt pulses |
| q_valid_o | output | 1 | Queue word valid |
| q_data_o | output | DW | Queue word |
| busy_o | output | 1 | Sequencer running |
| halted_o | output | 1 | Stopped by a halt entry or a bad opcode |
| err_o | output | 1 | Stopped by an unknown opcode |

## Verification
Several lists are run, and each one separates one group of behaviours:

- A mixed list of a plain message, an interrupt, a queue post, a bus-to-bus message, a jump and a halt. It tells descriptor addressing, entry order and pointer advance apart.
- A retry list with scripted outcomes: all failures, failure then success, and failure with retry disabled. It distinguishes the attempt count, the bus chosen per attempt and the block status encoding.
- A list with a bad opcode, and a single-frame list. These separate the two ways a run can end from a halt.
- Auto-repeat under the internal counter, timed across consecutive frames. This shows the period is exact.
- Auto-repeat under the external trigger, with a long pause before the trigger. This shows the counter is ignored and only the trigger edge restarts the frame.

// File: rtl/bcseq_pkg.sv
package bcseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_OP_RQ, S_OP_RD, S_PAR_RD, S_EXEC,
    S_D0, S_D1, S_D2, S_D3, S_GO, S_BUSY,
    S_WB0, S_WB1, S_WB2, S_WAIT
  } seq_state_e;

  localparam logic [3:0] OP_MSG  = 4'd0;
  localparam logic [3:0] OP_JMP  = 4'd1;
  localparam logic [3:0] OP_WAIT = 4'd2;
  localparam logic [3:0] OP_IRQ  = 4'd3;
  localparam logic [3:0] OP_QUE  = 4'd4;
  localparam logic [3:0] OP_HALT = 4'd5;

  // descriptor word offsets
  localparam int DO_CTRL  = 0;
  localparam int DO_CMD   = 1;
  localparam int DO_BSTAT = 5;
  localparam int DO_STAT  = 7;
  localparam int DO_CMD2  = 8;
  localparam int DO_STAT2 = 9;

  // control word bits
  localparam int CB_RETRY = 0;
  localparam int CB_B2B   = 1;
  localparam int CB_BUS   = 2;
endpackage

// File: rtl/bcseq_frame_src.sv
module bcseq_frame_src #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          run_i,
  input  logic          ext_mode_i,
  input  logic [TW-1:0] period_i,
  input  logic          ext_trig_i,
  input  logic          take_i,
  output logic          pend_o
);
  logic [TW-1:0] cnt_q;
  logic          trig_q, pend_q;
  logic          tmr_evt, ext_evt;

  assign tmr_evt = run_i && !ext_mode_i && (cnt_q == '0) && !arm_i;
  assign ext_evt = run_i && ext_mode_i && ext_trig_i && !trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trig_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      trig_q <= ext_trig_i;
      if (arm_i)
        cnt_q <= period_i - TW'(1);
      else if (run_i && !ext_mode_i)
        cnt_q <= (cnt_q == '0) ? period_i - TW'(1) : cnt_q - TW'(1);
      if (arm_i) pend_q <= 1'b0;
      else       pend_q <= (pend_q && !take_i) || tmr_evt || ext_evt;
    end
  end

  assign pend_o = pend_q;

  assert_ext_no_timer_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && !ext_trig_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/bcseq_retry.sv
module bcseq_retry #(
  parameter int MAX_RETRY = 2,
  parameter int RW = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          fail_i,
  output logic          again_o,
  output logic          final_o,
  output logic [RW-1:0] cnt_o
);
  logic [RW-1:0] cnt_q;

  assign final_o = (cnt_q == RW'(MAX_RETRY));
  assign again_o = fail_i && !final_o;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (again_o) cnt_q <= cnt_q + RW'(1);
  end

  assert_retry_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RW'(MAX_RETRY));
  assert_retry_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !again_o) |=> $stable(cnt_q));
endmodule

// File: rtl/bcseq_top.sv
module bcseq_top
  import bcseq_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int TW        = 16,
  parameter int NIRQ      = 4,
  parameter int MAX_RETRY = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            ptr_load_i,
  input  logic [AW-1:0]   ptr_init_i,
  output logic [AW-1:0]   ptr_o,
  input  logic            auto_rep_i,
  input  logic            ext_mode_i,
  input  logic [TW-1:0]   frame_period_i,
  input  logic            ext_trig_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            msg_start_o,
  output logic [DW-1:0]   msg_ctrl_o,
  output logic [DW-1:0]   msg_cmd_o,
  output logic [DW-1:0]   msg_cmd2_o,
  output logic            msg_bus_o,
  input  logic            msg_done_i,
  input  logic            msg_ok_i,
  input  logic [DW-1:0]   msg_stat_i,
  input  logic [DW-1:0]   msg_stat2_i,
  output logic [NIRQ-1:0] irq_o,
  output logic            q_valid_o,
  output logic [DW-1:0]   q_data_o,
  output logic            busy_o,
  output logic            halted_o,
  output logic            err_o
);
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam int RW = $clog2(MAX_RETRY + 1);

  seq_state_e    st_q;
  logic [AW-1:0] ptr_q, base_q;
  logic [3:0]    op_q;
  logic [DW-1:0] par_q, ctrl_q, cmd_q, cmd2_q, stat_q, stat2_q, qd_q;
  logic          ok_q, halted_q, err_q, qv_q;
  logic [NIRQ-1:0] irq_q;

  logic          arm, run, take, pend;
  logic          rt_clr, rt_fail, rt_again, rt_final;
  logic [RW-1:0] rt_cnt;
  logic [DW-1:0] bstat;
  logic [AW-1:0] par_a;

  assign par_a  = par_q[AW-1:0];
  assign busy_o = (st_q != S_IDLE);
  assign arm    = (st_q == S_IDLE) && start_i;
  assign run    = busy_o && auto_rep_i;
  assign take   = (st_q == S_WAIT) && pend;

  assign rt_clr  = (st_q == S_EXEC);
  assign rt_fail = (st_q == S_BUSY) && msg_done_i && !msg_ok_i && ctrl_q[CB_RETRY];

  bcseq_frame_src #(.TW(TW)) u_frame (
    .clk_i, .rst_ni, .arm_i(arm), .run_i(run), .ext_mode_i,
    .period_i(frame_period_i), .ext_trig_i, .take_i(take), .pend_o(pend)
  );

  bcseq_retry #(.MAX_RETRY(MAX_RETRY), .RW(RW)) u_retry (
    .clk_i, .rst_ni, .clr_i(rt_clr), .fail_i(rt_fail),
    .again_o(rt_again), .final_o(rt_final), .cnt_o(rt_cnt)
  );

  always_comb begin
    bstat          = '0;
    bstat[DW-1]    = 1'b1;
    bstat[DW-2]    = !ok_q;
    bstat[2]       = rt_final;
    bstat[RW-1:0]  = rt_cnt;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_q;
    mem_wdata_o = '0;
    unique case (st_q)
      S_OP_RQ:  mem_req_o = 1'b1;
      S_OP_RD:  begin mem_req_o = 1'b1; mem_addr_o = ptr_q + AW'(1); end
      S_D0:     begin mem_req_o = 1'b1; mem_addr_o = par_a + AW'(DO_CTRL); end
      S_D1:     begin mem_req_o = 1'b1; mem_addr_o = par_a + AW'(DO_CMD); end
      S_D2:     begin mem_req_o = ctrl_q[CB_B2B]; mem_addr_o = par_a + AW'(DO_CMD2); end
      S_WB0:    begin mem_req_o = 1'b1; mem_we_o = 1'b1;
                      mem_addr_o = par_a + AW'(DO_BSTAT); mem_wdata_o = bstat; end
      S_WB1:    begin mem_req_o = 1'b1; mem_we_o = 1'b1;
                      mem_addr_o = par_a + AW'(DO_STAT); mem_wdata_o = stat_q; end
      S_WB2:    begin mem_req_o = 1'b1; mem_we_o = 1'b1;
                      mem_addr_o = par_a + AW'(DO_STAT2); mem_wdata_o = stat2_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      ptr_q    <= '0;
      base_q   <= '0;
      op_q     <= '0;
      par_q    <= '0;
      ctrl_q   <= '0;
      cmd_q    <= '0;
      cmd2_q   <= '0;
      stat_q   <= '0;
      stat2_q  <= '0;
      qd_q     <= '0;
      ok_q     <= 1'b0;
      halted_q <= 1'b0;
      err_q    <= 1'b0;
      qv_q     <= 1'b0;
      irq_q    <= '0;
    end else begin
      irq_q <= '0;
      qv_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (ptr_load_i) ptr_q <= ptr_init_i;
          else if (start_i) begin
            base_q   <= ptr_q;
            halted_q <= 1'b0;
            err_q    <= 1'b0;
            st_q     <= S_OP_RQ;
          end
        end
        S_OP_RQ:  st_q <= S_OP_RD;
        S_OP_RD:  begin op_q <= mem_rdata_i[3:0]; st_q <= S_PAR_RD; end
        S_PAR_RD: begin par_q <= mem_rdata_i; ptr_q <= ptr_q + AW'(2); st_q <= S_EXEC; end
        S_EXEC: begin
          unique case (op_q)
            OP_MSG:  st_q <= S_D0;
            OP_JMP:  begin ptr_q <= par_a; st_q <= S_OP_RQ; end
            OP_WAIT: st_q <= auto_rep_i ? S_WAIT : S_IDLE;
            OP_IRQ:  begin irq_q[par_q[IW-1:0]] <= 1'b1; st_q <= S_OP_RQ; end
            OP_QUE:  begin qv_q <= 1'b1; qd_q <= par_q; st_q <= S_OP_RQ; end
            OP_HALT: begin halted_q <= 1'b1; st_q <= S_IDLE; end
            default: begin halted_q <= 1'b1; err_q <= 1'b1; st_q <= S_IDLE; end
          endcase
        end
        S_D0: st_q <= S_D1;
        S_D1: begin ctrl_q <= mem_rdata_i; st_q <= S_D2; end
        S_D2: begin
          cmd_q <= mem_rdata_i;
          st_q  <= ctrl_q[CB_B2B] ? S_D3 : S_GO;
        end
        S_D3: begin cmd2_q <= mem_rdata_i; st_q <= S_GO; end
        S_GO: st_q <= S_BUSY;
        S_BUSY: begin
          if (msg_done_i) begin
            ok_q    <= msg_ok_i;
            stat_q  <= msg_stat_i;
            stat2_q <= msg_stat2_i;
            st_q    <= rt_again ? S_GO : S_WB0;
          end
        end
        S_WB0: st_q <= S_WB1;
        S_WB1: st_q <= ctrl_q[CB_B2B] ? S_WB2 : S_OP_RQ;
        S_WB2: st_q <= S_OP_RQ;
        S_WAIT: begin
          if (pend) begin ptr_q <= base_q; st_q <= S_OP_RQ; end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ptr_o       = ptr_q;
  assign msg_start_o = (st_q == S_GO);
  assign msg_ctrl_o  = ctrl_q;
  assign msg_cmd_o   = cmd_q;
  assign msg_cmd2_o  = cmd2_q;
  assign msg_bus_o   = ctrl_q[CB_BUS] ^ rt_final;
  assign irq_o       = irq_q;
  assign q_valid_o   = qv_q;
  assign q_data_o    = qd_q;
  assign halted_o    = halted_q;
  assign err_o       = err_q;

  assert_irq_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  assert_q_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |=> !q_valid_o);
  assert_halt_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !busy_o);
  assert_err_halts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> halted_o);
  assert_start_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_start_o |-> (busy_o && !mem_req_o));
  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_EXEC) |-> (ptr_q == $past(ptr_q, 2) + AW'(2)));
endmodule

// File: tb/sim_bcseq_top.sv
module sim_bcseq_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 0, ptr_load = 0, auto_rep = 0, ext_mode = 0, ext_trig = 0;
  logic [AW-1:0] ptr_init = '0;
  logic [TW-1:0] period = 16'd10;
  logic [AW-1:0] ptr, mem_addr;
  logic mem_req, mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic msg_start, msg_bus, msg_done = 0, msg_ok = 0;
  logic [DW-1:0] msg_ctrl, msg_cmd, msg_cmd2, msg_stat, msg_stat2;
  logic [3:0] irq;
  logic q_valid, busy, halted, err;
  logic [DW-1:0] q_data;

  assign msg_stat  = {4'hA, msg_cmd[11:0]};
  assign msg_stat2 = {4'hB, msg_cmd2[11:0]};

  bcseq_top #(.AW(AW), .DW(DW), .TW(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ptr_load_i(ptr_load),
    .ptr_init_i(ptr_init), .ptr_o(ptr), .auto_rep_i(auto_rep), .ext_mode_i(ext_mode),
    .frame_period_i(period), .ext_trig_i(ext_trig), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .msg_start_o(msg_start), .msg_ctrl_o(msg_ctrl), .msg_cmd_o(msg_cmd), .msg_cmd2_o(msg_cmd2),
    .msg_bus_o(msg_bus), .msg_done_i(msg_done), .msg_ok_i(msg_ok), .msg_stat_i(msg_stat),
    .msg_stat2_i(msg_stat2), .irq_o(irq), .q_valid_o(q_valid), .q_data_o(q_data),
    .busy_o(busy), .halted_o(halted), .err_o(err)
  );

  logic [15:0] mem [0:255];
  logic [15:0] img [0:255];
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  int checks = 0, fails = 0, cyc = 0, n_start = 0;
  int t_start[$];
  logic [63:0] exp_q[$];
  bit drv_out[$], mdl_out[$];
  bit cmp_en = 0;
  int eng_cnt = 0;

  function automatic logic [63:0] mk(input int k, input int a, input int b);
    return {k[7:0], a[23:0], b[31:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic obs(input logic [63:0] e);
    string rq;
    case (e[63:56])
      8'd1: rq = "R4"; 8'd2: rq = "R3"; 8'd3: rq = "R8"; default: rq = "R9";
    endcase
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL %s unexpected event: actual %h expected none", rq, e);
    end else begin
      logic [63:0] x;
      x = exp_q.pop_front();
      if (x !== e) begin
        fails++;
        $display("FAIL %s event mismatch: actual %h expected %h", rq, e, x);
      end
    end
  endtask

  // per-clock comparison against the reference event stream
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      if (mem_req && mem_we) obs(mk(1, int'(mem_addr), int'(mem_wdata)));
      if (msg_start) begin
        n_start++;
        t_start.push_back(cyc);
        obs(mk(2, int'(msg_cmd), int'({15'h0, msg_bus, msg_ctrl[1] ? msg_cmd2 : 16'h0})));
      end
      if (|irq)    obs(mk(3, 0, int'(irq)));
      if (q_valid) obs(mk(4, 0, int'(q_data)));
    end
  end

  // message engine: done three cycles after start
  always @(negedge clk) begin
    if (!rst_n) begin
      eng_cnt = 0; msg_done = 0;
    end else begin
      msg_done = 0;
      if (eng_cnt > 0) begin
        eng_cnt--;
        if (eng_cnt == 0) begin
          msg_done = 1;
          msg_ok = (drv_out.size() > 0) ? drv_out.pop_front() : 1'b1;
        end
      end
      if (msg_start) eng_cnt = 3;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic put(input int a, input logic [15:0] v);
    mem[a] = v; img[a] = v;
  endtask

  task automatic outcome(input bit ok);
    drv_out.push_back(ok); mdl_out.push_back(ok);
  endtask

  // behavioural list interpreter producing the expected event stream
  task automatic model_run(input int sp, input bit am, input int frames,
                           output int fp, output bit he, output bit ee);
    int p, fr, r;
    logic [15:0] op, par, ctrl, cmd, cmd2;
    logic [1:0] r2;
    bit ok, bus;
    p = sp; fr = 0; he = 0; ee = 0; fp = 0;
    for (int g = 0; g < 200; g++) begin
      op = img[p & 255]; par = img[(p + 1) & 255]; p += 2;
      case (op[3:0])
        4'd0: begin
          ctrl = img[par & 255]; cmd = img[(par + 1) & 255];
          cmd2 = ctrl[1] ? img[(par + 8) & 255] : 16'h0;
          r = 0; ok = 1;
          for (int a = 0; a < 3; a++) begin
            bus = ctrl[2] ^ (r == 2);
            exp_q.push_back(mk(2, int'(cmd), int'({15'h0, bus, cmd2})));
            ok = (mdl_out.size() > 0) ? mdl_out.pop_front() : 1'b1;
            if (ok || !ctrl[0] || r == 2) break;
            r++;
          end
          r2 = r[1:0];
          exp_q.push_back(mk(1, int'(par) + 5, int'({1'b1, ~ok, 11'h0, (r == 2), r2})));
          exp_q.push_back(mk(1, int'(par) + 7, int'({4'hA, cmd[11:0]})));
          if (ctrl[1]) exp_q.push_back(mk(1, int'(par) + 9, int'({4'hB, cmd2[11:0]})));
        end
        4'd1: p = int'(par);
        4'd2: begin
          if (!am) begin fp = p; return; end
          fr++;
          if (fr >= frames) begin fp = p; return; end
          p = sp;
        end
        4'd3: exp_q.push_back(mk(3, 0, 1 << par[1:0]));
        4'd4: exp_q.push_back(mk(4, 0, int'(par)));
        4'd5: begin he = 1; fp = p; return; end
        default: begin he = 1; ee = 1; fp = p; return; end
      endcase
    end
    fp = p;
  endtask

  task automatic do_reset();
    cmp_en = 0; rst_n = 0;
    exp_q.delete(); drv_out.delete(); mdl_out.delete(); t_start.delete();
    start = 0; ptr_load = 0; ext_trig = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    chk(!busy && !halted && !err, "R1", "idle flags after reset", {busy, halted, err}, 0);
    chk(irq == 0 && !q_valid && !msg_start, "R1", "pulses after reset", {irq, q_valid, msg_start}, 0);
    chk(ptr == 0, "R1", "pointer after reset", int'(ptr), 0);
    n_start = 0;
    cmp_en = 1;
  endtask

  task automatic launch(input int sp);
    ptr_init = AW'(sp); ptr_load = 1;
    step();
    ptr_load = 0;
    chk(ptr == AW'(sp), "R2", "pointer load", int'(ptr), sp);
    start = 1;
    step();
    start = 0;
  endtask

  task automatic wait_done(input int maxc, input bit need_idle, input string req);
    int n;
    n = 0;
    while ((exp_q.size() != 0 || (need_idle && busy)) && n < maxc) begin
      step(); n++;
    end
    chk(n < maxc, req, "completion within limit", n, maxc);
    chk(exp_q.size() == 0, req, "expected events left", exp_q.size(), 0);
  endtask

  int fp;
  bit he, ee;

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; img[i] = 16'h0; end
    do_reset();

    // T1: mixed list, R2 R3 R4 R7 R8 R9 R10
    put(16'h10, 0); put(16'h11, 16'h40);
    put(16'h12, 3); put(16'h13, 16'h2);
    put(16'h14, 4); put(16'h15, 16'h1234);
    put(16'h16, 0); put(16'h17, 16'h60);
    put(16'h18, 1); put(16'h19, 16'h30);
    put(16'h30, 5); put(16'h31, 0);
    put(16'h40, 16'h0000); put(16'h41, 16'h0C21);
    put(16'h60, 16'h0006); put(16'h61, 16'h1C22); put(16'h68, 16'h2C23);
    auto_rep = 0; ext_mode = 0;
    model_run(16'h10, 0, 1, fp, he, ee);
    launch(16'h10);
    wait_done(2000, 1, "R3");
    chk(ptr == AW'(fp), "R7", "pointer after jump and halt", int'(ptr), fp);
    chk(halted == 1 && err == 0, "R10", "halt flags", {halted, err}, 2);
    chk(mem[16'h69] == 16'hBC23, "R4", "second status word", int'(mem[16'h69]), 16'hBC23);
    chk(mem[16'h45] == 16'h8000, "R4", "block status success", int'(mem[16'h45]), 16'h8000);

    // T2: retries, R5 R6
    do_reset();
    put(16'h80, 0); put(16'h81, 16'hA0);
    put(16'h82, 0); put(16'h83, 16'hB0);
    put(16'h84, 0); put(16'h85, 16'hC0);
    put(16'h86, 5); put(16'h87, 0);
    put(16'hA0, 16'h0001); put(16'hA1, 16'h0C31);
    put(16'hB0, 16'h0005); put(16'hB1, 16'h0C32);
    put(16'hC0, 16'h0000); put(16'hC1, 16'h0C33);
    outcome(0); outcome(0); outcome(0);
    outcome(0); outcome(1);
    outcome(0);
    model_run(16'h80, 0, 1, fp, he, ee);
    launch(16'h80);
    wait_done(2000, 1, "R5");
    chk(mem[16'hA5] == 16'hC006, "R5", "status after all retries fail", int'(mem[16'hA5]), 16'hC006);
    chk(mem[16'hB5] == 16'h8001, "R5", "status after one retry", int'(mem[16'hB5]), 16'h8001);
    chk(mem[16'hC5] == 16'hC000, "R6", "status with retry off", int'(mem[16'hC5]), 16'hC000);
    chk(n_start == 6, "R6", "total attempts", n_start, 6);

    // T3: unknown opcode, R10
    do_reset();
    put(16'hD0, 4); put(16'hD1, 16'h0055);
    put(16'hD2, 7); put(16'hD3, 0);
    model_run(16'hD0, 0, 1, fp, he, ee);
    launch(16'hD0);
    wait_done(500, 1, "R10");
    chk(halted && err, "R10", "bad opcode flags", {halted, err}, 3);
    chk(ptr == 12'hD4, "R10", "pointer after bad opcode", int'(ptr), 16'hD4);

    // T4: single frame, R11
    do_reset();
    put(16'hE0, 0); put(16'hE1, 16'h40);
    put(16'hE2, 2); put(16'hE3, 0);
    model_run(16'hE0, 0, 1, fp, he, ee);
    launch(16'hE0);
    wait_done(500, 1, "R11");
    chk(!busy && !halted && !err, "R11", "end of single frame", {busy, halted, err}, 0);
    chk(ptr == 12'hE4, "R11", "pointer after frame end", int'(ptr), 16'hE4);

    // T5: auto-repeat on internal counter, R12
    do_reset();
    auto_rep = 1; ext_mode = 0; period = 16'd80;
    model_run(16'hE0, 1, 4, fp, he, ee);
    launch(16'hE0);
    wait_done(2000, 0, "R12");
    chk(t_start.size() == 4, "R12", "frames run", t_start.size(), 4);
    if (t_start.size() == 4) begin
      chk(t_start[2] - t_start[1] == 80, "R12", "frame interval 2-3", t_start[2] - t_start[1], 80);
      chk(t_start[3] - t_start[2] == 80, "R12", "frame interval 3-4", t_start[3] - t_start[2], 80);
    end
    chk(busy, "R12", "still running while waiting", busy, 1);

    // T6: auto-repeat on external trigger, R13
    do_reset();
    auto_rep = 1; ext_mode = 1; period = 16'd5;
    model_run(16'hE0, 1, 2, fp, he, ee);
    launch(16'hE0);
    repeat (200) step();
    chk(n_start == 1, "R13", "no restart without trigger", n_start, 1);
    chk(exp_q.size() == 3, "R13", "second frame pending", exp_q.size(), 3);
    ext_trig = 1; step(); ext_trig = 0;
    wait_done(500, 0, "R13");
    chk(n_start == 2, "R13", "restart after trigger", n_start, 2);

    do_reset();
    auto_rep = 0; ext_mode = 0;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule